// File: doc/BRIEF.md
# Interrupt Sampling and Priority Controller

This block sits beside a small CPU core and decides which interrupt the core should take at the end of an instruction. It samples a set of active-low external request pins on every clock and keeps one pending flag per source. Each pin can be set to react either to a falling edge or to a low level. Internal peripherals raise their flags with a one-cycle set pulse. Every source has a two-bit priority, giving four levels.

The core marks the next-to-last and the last cycle of each instruction with two strobes. In the last cycle the block chooses among flags that were already pending before that cycle began. It then raises a registered vector request carrying the source number and its level. The request holds until the core acknowledges it. The acknowledge clears the source's flag and pushes the level onto a small in-service stack. A return-from-interrupt strobe pops that stack. While a handler runs, only sources at a strictly higher level can break in. Vector fetch, stacking of the program counter and the core itself live elsewhere.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all pending flags, the request output and the in-service stack. After reset no request appears until a new event arrives.
- R2: An external pin in edge mode (ext_edge bit = 1) is sampled every clock. A high sample followed on the next clock by a low sample sets that source's flag. A pin held low does not set the flag again after it has been acknowledged.
- R3: An external pin in level mode (ext_edge bit = 0) has a flag that follows its latest sample (low = active). The acknowledge does not clear it, and the flag disappears once the pin is sampled high.
- R4: A decision is made only in a cycle with cyc_last high. The decision uses only flags that were pending at the clock edge that closed the preceding strobed cycle (cyc_penult or cyc_last), so a flag that first appears during the last cycle waits for the next boundary. The result shows on irq_valid after the edge that closes the last cycle.
- R5: The level of source i is src_prio[2i+1:2i], and 3 is the highest. The eligible source with the highest level is requested, and irq_level reports that level.
- R6: Sources are numbered with the external pins first (0 to N_EXT-1) and the internal sources after them. When eligible sources share the top level, the lowest number wins.
- R7: While glob_en is low, no request is raised. Pending flags stay set and are requested once glob_en returns high.
- R8: While src_en[i] is low, source i is not requested. Its flag stays set and is requested once the enable returns.
- R9: irq_ack while irq_valid is high drops irq_valid on the next cycle. It also clears the flag of the granted source (in edge mode or internal) and records the granted level as in service.
- R10: While a level L is in service, only sources with a level above L can be requested. Nesting goes up to four levels deep.
- R11: irq_reti removes the most recent in-service level, and sources at lower levels become eligible again.
- R12: While irq_valid is high and no acknowledge arrives, irq_valid, irq_id and irq_level stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | N_EXT | Active-low external request pins |
| ext_edge | input | N_EXT | Per pin: 1 = falling-edge, 0 = low-level |
| int_req | input | N_INT | One-cycle set pulses from internal sources |
| src_en | input | N_EXT+N_INT | Per-source enable |
| glob_en | input | 1 | Global enable |
| src_prio | input | 2*(N_EXT+N_INT) | Two-bit level per source |
| cyc_penult | input | 1 | CPU is in the next-to-last cycle of an instruction |
| cyc_last | input | 1 | CPU is in the last cycle of an instruction |
| irq_ack | input | 1 | CPU accepts the current request |
| irq_reti | input | 1 | CPU returns from the current handler |
| irq_valid | output | 1 | A vector request is presented |
| irq_id | output | ID_W | Number of the requested source |
| irq_level | output | 2 | Level of the requested source |

## Verification
A flag latched one cycle too early or too late shows up as irq_valid rising one instruction boundary away from the expected one. That is visible within two strobed cycles of the event. A corrupted in-service stack shows up either as a request that breaks into a handler at the wrong level, or as a lower request that never appears after a return. A wrong arbitration order shows up as a wrong irq_id in the very cycle the request rises. The bench drives directed boundary cases and long random stretches. It compares the ports on every cycle against a model built from these rules.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irqc_pin_sampler.sv
`timescale 1ns/1ps
// Samples each active-low pin on every clock and keeps the previous sample,
// so a falling edge is a high sample followed by a low one.
module irqc_pin_sampler #(
  parameter int N_PIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PIN-1:0] pin_n,
  output logic [N_PIN-1:0] fall,
  output logic [N_PIN-1:0] low
);
  logic [N_PIN-1:0] smp_q;
  logic [N_PIN-1:0] prv_q;

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        smp_q[g] <= 1'b1;
        prv_q[g] <= 1'b1;
      end else begin
        smp_q[g] <= pin_n[g];
        prv_q[g] <= smp_q[g];
      end
    end
    assign fall[g] = prv_q[g] & ~smp_q[g];
    assign low[g]  = ~smp_q[g];
  end
endmodule

// File: rtl/irqc_flags.sv
`timescale 1ns/1ps
// Pending flags per source and the snapshot used at the instruction boundary.
module irqc_flags #(
  parameter int N_EXT = 2,
  parameter int N_INT = 6,
  localparam int N_SRC = N_EXT + N_INT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_fall,
  input  logic [N_EXT-1:0] ext_low,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic [N_INT-1:0] int_set,
  input  logic [N_SRC-1:0] clr_vec,
  input  logic             snap_en,
  output logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] snap
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    if (g < N_EXT) begin : g_ext
      always_ff @(posedge clk) begin
        if (rst)
          pend[g] <= 1'b0;
        else if (ext_edge[g])
          pend[g] <= (pend[g] & ~clr_vec[g]) | ext_fall[g];
        else
          pend[g] <= ext_low[g];
      end
    end else begin : g_int
      always_ff @(posedge clk) begin
        if (rst)
          pend[g] <= 1'b0;
        else
          pend[g] <= (pend[g] & ~clr_vec[g]) | int_set[g-N_EXT];
      end
    end
  end

  // Captured at the close of every strobed cycle: for a multi-cycle
  // instruction the last capture before the final cycle is the
  // next-to-last cycle, for a one-cycle instruction it is the previous
  // instruction's final cycle.
  always_ff @(posedge clk) begin
    if (rst)
      snap <= '0;
    else if (snap_en)
      snap <= pend & ~clr_vec;
  end
endmodule

// File: rtl/irqc_pick.sv
`timescale 1ns/1ps
// Highest level wins; equal levels resolved toward the lowest index.
module irqc_pick
  import irqc_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       cand,
  input  logic [LVL_W*N_SRC-1:0] prio,
  output logic                   found,
  output logic [ID_W-1:0]        id,
  output lvl_t                   lvl
);
  always_comb begin
    found = 1'b0;
    id    = '0;
    lvl   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio[LVL_W*i +: LVL_W] >= lvl)) begin
        found = 1'b1;
        id    = ID_W'(i);
        lvl   = prio[LVL_W*i +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irqc_svc_stack.sv
`timescale 1ns/1ps
// Stack of levels currently in service.
module irqc_svc_stack
  import irqc_pkg::*;
#(
  parameter int DEPTH = NUM_LVL,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output logic active,
  output lvl_t top_lvl
);
  lvl_t             stk [DEPTH];
  logic [CNT_W-1:0] depth;
  logic [CNT_W-1:0] depth_m1;
  logic             do_pop;
  logic             full;

  assign depth_m1 = depth - CNT_W'(1);
  assign do_pop   = pop && (depth != '0);
  assign full     = (depth == CNT_W'(DEPTH));
  assign active   = (depth != '0);
  assign top_lvl  = active ? stk[depth_m1[PTR_W-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
    end else if (do_pop && push) begin
      stk[depth_m1[PTR_W-1:0]] <= push_lvl;
    end else if (do_pop) begin
      depth <= depth_m1;
    end else if (push && !full) begin
      stk[depth[PTR_W-1:0]] <= push_lvl;
      depth <= depth + CNT_W'(1);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int N_EXT = 2,
  parameter int N_INT = 6,
  localparam int N_SRC = N_EXT + N_INT,
  localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_EXT-1:0]       ext_pin_n,
  input  logic [N_EXT-1:0]       ext_edge,
  input  logic [N_INT-1:0]       int_req,
  input  logic [N_SRC-1:0]       src_en,
  input  logic                   glob_en,
  input  logic [LVL_W*N_SRC-1:0] src_prio,
  input  logic                   cyc_penult,
  input  logic                   cyc_last,
  input  logic                   irq_ack,
  input  logic                   irq_reti,
  output logic                   irq_valid,
  output logic [ID_W-1:0]        irq_id,
  output lvl_t                   irq_level
);
  logic [N_EXT-1:0] ext_fall;
  logic [N_EXT-1:0] ext_low;
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] snap;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] above;
  logic [N_SRC-1:0] cand;
  logic             take;
  logic             pick_found;
  logic [ID_W-1:0]  pick_id;
  lvl_t             pick_lvl;
  logic             svc_active;
  lvl_t             svc_top;

  assign take = irq_valid && irq_ack;

  always_comb begin
    clr_vec = '0;
    if (take)
      clr_vec[irq_id] = 1'b1;
  end

  irqc_pin_sampler #(.N_PIN(N_EXT)) u_pins (
    .clk   (clk),
    .rst   (rst),
    .pin_n (ext_pin_n),
    .fall  (ext_fall),
    .low   (ext_low)
  );

  irqc_flags #(.N_EXT(N_EXT), .N_INT(N_INT)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .ext_fall (ext_fall),
    .ext_low  (ext_low),
    .ext_edge (ext_edge),
    .int_set  (int_req),
    .clr_vec  (clr_vec),
    .snap_en  (cyc_penult | cyc_last),
    .pend     (pend),
    .snap     (snap)
  );

  irqc_svc_stack #(.DEPTH(NUM_LVL)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (take),
    .push_lvl (irq_level),
    .pop      (irq_reti),
    .active   (svc_active),
    .top_lvl  (svc_top)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_above
    assign above[g] = !svc_active || (src_prio[LVL_W*g +: LVL_W] > svc_top);
  end

  assign cand = snap & pend & src_en & {N_SRC{glob_en}} & above;

  irqc_pick #(.N_SRC(N_SRC)) u_pick (
    .cand  (cand),
    .prio  (src_prio),
    .found (pick_found),
    .id    (pick_id),
    .lvl   (pick_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
      irq_level <= '0;
    end else if (take) begin
      irq_valid <= 1'b0;
    end else if (!irq_valid && cyc_last && pick_found) begin
      irq_valid <= 1'b1;
      irq_id    <= pick_id;
      irq_level <= pick_lvl;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
`timescale 1ns/1ps
module irq_prio_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int N_EXT = 2,
  parameter int N_INT = 6,
  localparam int N_SRC = N_EXT + N_INT,
  localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_SRC-1:0]       src_en,
  input logic                   glob_en,
  input logic [LVL_W*N_SRC-1:0] src_prio,
  input logic                   cyc_last,
  input logic                   irq_ack,
  input logic                   irq_valid,
  input logic [ID_W-1:0]        irq_id,
  input lvl_t                   irq_level,
  input logic                   svc_active,
  input lvl_t                   svc_top
);
  logic [N_SRC-1:0]       en_q;
  logic [LVL_W*N_SRC-1:0] prio_q;

  always_ff @(posedge clk) begin
    en_q   <= src_en;
    prio_q <= src_prio;
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !irq_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_id) && $stable(irq_level));

  a_r9_ack_drop: assert property (@(posedge clk) disable iff (rst)
    irq_valid && irq_ack |=> !irq_valid);

  a_r4_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> $past(cyc_last));

  a_r7_global_mask: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> $past(glob_en));

  a_r8_source_mask: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> en_q[irq_id]);

  a_r5_level_match: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> irq_level == prio_q[LVL_W*int'(irq_id) +: LVL_W]);

  a_r10_nest_above: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) && $past(svc_active) |-> irq_level > $past(svc_top));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_EXT(N_EXT), .N_INT(N_INT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_en     (src_en),
  .glob_en    (glob_en),
  .src_prio   (src_prio),
  .cyc_last   (cyc_last),
  .irq_ack    (irq_ack),
  .irq_valid  (irq_valid),
  .irq_id     (irq_id),
  .irq_level  (irq_level),
  .svc_active (svc_active),
  .svc_top    (svc_top)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  localparam int N_EXT = 2;
  localparam int N_INT = 6;
  localparam int N_SRC = N_EXT + N_INT;
  localparam int ID_W  = $clog2(N_SRC);

  logic clk = 1'b0;
  logic rst;
  logic [N_EXT-1:0]   pin_n;
  logic [N_EXT-1:0]   edge_m;
  logic [N_INT-1:0]   ireq;
  logic [N_SRC-1:0]   en;
  logic               glob;
  logic [2*N_SRC-1:0] prio;
  logic               penult, last, ack, reti;
  logic               irq_valid;
  logic [ID_W-1:0]    irq_id;
  logic [1:0]         irq_level;

  int n_cmp = 0;
  int n_bad = 0;
  int rem   = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.N_EXT(N_EXT), .N_INT(N_INT)) u_dut (
    .clk(clk), .rst(rst), .ext_pin_n(pin_n), .ext_edge(edge_m), .int_req(ireq),
    .src_en(en), .glob_en(glob), .src_prio(prio), .cyc_penult(penult),
    .cyc_last(last), .irq_ack(ack), .irq_reti(reti),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_level(irq_level)
  );

  // Reference model written from the requirements.
  logic [N_SRC-1:0] m_pend, m_snap;
  logic [N_EXT-1:0] m_smp, m_prv;
  bit m_valid;
  int m_id, m_lvl, m_depth;
  int m_stk [4];

  always @(posedge clk) begin : mdl
    logic [N_SRC-1:0] clr, np;
    int best, blvl, top, l;
    bit push, pop;
    if (rst) begin
      m_pend = '0; m_snap = '0; m_smp = '1; m_prv = '1;
      m_valid = 0; m_id = 0; m_lvl = 0; m_depth = 0;
    end else begin
      clr = '0;
      if (m_valid && ack) clr[m_id] = 1'b1;
      top = (m_depth > 0) ? m_stk[m_depth-1] : -1;
      best = -1; blvl = -1;
      for (int i = 0; i < N_SRC; i++) begin
        l = int'(prio[2*i +: 2]);
        if (m_snap[i] && m_pend[i] && en[i] && glob && l > top && l > blvl) begin
          best = i; blvl = l;
        end
      end
      push = m_valid && ack;
      pop  = reti && (m_depth > 0);
      if (pop && push) m_stk[m_depth-1] = m_lvl;
      else if (pop) m_depth--;
      else if (push && m_depth < 4) begin m_stk[m_depth] = m_lvl; m_depth++; end
      if (m_valid && ack) m_valid = 0;
      else if (!m_valid && last && best >= 0) begin m_valid = 1; m_id = best; m_lvl = blvl; end
      for (int i = 0; i < N_SRC; i++) begin
        if (i < N_EXT)
          np[i] = edge_m[i] ? ((m_pend[i] & ~clr[i]) | (m_prv[i] & ~m_smp[i])) : ~m_smp[i];
        else
          np[i] = (m_pend[i] & ~clr[i]) | ireq[i-N_EXT];
      end
      if (penult || last) m_snap = m_pend & ~clr;
      m_prv = m_smp; m_smp = pin_n; m_pend = np;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (irq_valid !== m_valid ||
          (m_valid && (int'(irq_id) != m_id || int'(irq_level) != m_lvl))) begin
        n_bad++;
        $display("FAIL R5 R6 R10 R12 model: valid=%0b id=%0d lvl=%0d expected valid=%0b id=%0d lvl=%0d",
                 irq_valid, irq_id, irq_level, m_valid, m_id, m_lvl);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask
  task automatic idle(input int n);
    penult = 0; last = 0; tick(n);
  endtask
  task automatic run_last(input int n);
    penult = 0; last = 1; tick(n); last = 0;
  endtask
  task automatic do_ack;
    ack = 1; tick(1); ack = 0;
  endtask
  task automatic do_reti;
    reti = 1; tick(1); reti = 0;
  endtask
  task automatic pulse(input logic [N_INT-1:0] v);
    ireq = v; tick(1); ireq = '0;
  endtask
  task automatic chk(input bit ev, input int eid, input int elv, input string tag);
    n_cmp++;
    if (irq_valid !== ev || (ev && (int'(irq_id) != eid || int'(irq_level) != elv))) begin
      n_bad++;
      $display("FAIL %s: valid=%0b id=%0d lvl=%0d expected valid=%0b id=%0d lvl=%0d",
               tag, irq_valid, irq_id, irq_level, ev, eid, elv);
    end
  endtask
  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #4000000;
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; pin_n = '1; edge_m = 2'b01; ireq = '0; en = '1; glob = 1;
    prio = '0; penult = 0; last = 0; ack = 0; reti = 0;
    tick(3);
    chk(0, 0, 0, "R1 during reset");
    rst = 0;
    run_last(4);
    chk(0, 0, 0, "R1 idle after reset");

    // R2 edge mode on pin 0, R4 snapshot delay
    pin_n[0] = 0; idle(3);
    run_last(1); chk(0, 0, 0, "R4 flag not yet in snapshot");
    run_last(1); chk(1, 0, 0, "R2 falling edge request");
    do_ack; chk(0, 0, 0, "R9 ack drops request");
    do_reti;
    run_last(4); chk(0, 0, 0, "R2 pin held low no retrigger");
    pin_n[0] = 1; idle(2); pin_n[0] = 0; idle(3);
    run_last(2); chk(1, 0, 0, "R2 second falling edge");
    do_ack; do_reti; pin_n[0] = 1;

    // R3 level mode on pin 1
    pin_n[1] = 0; idle(3);
    run_last(2); chk(1, 1, 0, "R3 level request");
    do_ack; do_reti;
    run_last(2); chk(1, 1, 0, "R3 level flag survives ack");
    do_ack; pin_n[1] = 1; do_reti; idle(3);
    run_last(3); chk(0, 0, 0, "R3 level flag gone after pin high");

    // R5 R6 R10 R11 R12: levels src2=1 src3=3 src4=3 src5=2
    prio = '0;
    prio[5:4] = 2'd1; prio[7:6] = 2'd3; prio[9:8] = 2'd3; prio[11:10] = 2'd2;
    pulse(6'b001111); idle(1);
    run_last(2); chk(1, 3, 3, "R5 R6 highest level lowest index");
    do_ack;
    run_last(3); chk(0, 0, 0, "R10 same level blocked");
    do_reti;
    run_last(2); chk(1, 4, 3, "R11 released after return");
    do_ack; do_reti;
    run_last(2); chk(1, 5, 2, "R5 next level");
    run_last(3); chk(1, 5, 2, "R12 request held without ack");
    do_ack;
    pulse(6'b000010); idle(1);
    run_last(2); chk(1, 3, 3, "R10 higher level nests");
    do_ack; do_reti;
    run_last(3); chk(0, 0, 0, "R10 lower level blocked");
    do_reti;
    run_last(2); chk(1, 2, 1, "R11 lowest level after unwinding");
    do_ack; do_reti;

    // R7 global mask
    glob = 0; pulse(6'b010000); idle(1);
    run_last(4); chk(0, 0, 0, "R7 global mask");
    glob = 1;
    run_last(2); chk(1, 6, 0, "R7 flag kept while masked");
    do_ack; do_reti;

    // R8 source mask
    en[7] = 0; pulse(6'b100000); idle(1);
    run_last(4); chk(0, 0, 0, "R8 source mask");
    en = '1;
    run_last(2); chk(1, 7, 0, "R8 flag kept while masked");
    do_ack; do_reti;

    // R4 multi-cycle instruction: flag before vs during next-to-last cycle
    ireq = 6'b000001; tick(1); ireq = '0;
    penult = 1; tick(1); penult = 0; last = 1; tick(1); last = 0;
    chk(1, 2, 1, "R4 flag latched before next-to-last cycle");
    do_ack; do_reti;
    tick(1);
    penult = 1; ireq = 6'b000001; tick(1); ireq = '0; penult = 0;
    last = 1; tick(1); last = 0;
    chk(0, 0, 0, "R4 flag latched in next-to-last cycle waits");
    run_last(1); chk(1, 2, 1, "R4 taken at following boundary");
    do_ack; do_reti;

    // Random stretch
    for (int ph = 0; ph < 4; ph++) begin
      prio = 16'($urandom); en = N_SRC'($urandom) | 8'h81; edge_m = 2'($urandom);
      for (int c = 0; c < 3000; c++) begin
        if (rem == 0) rem = 1 + int'($urandom % 4);
        last = (rem == 1); penult = (rem == 2); rem--;
        ack  = irq_valid && ($urandom % 3 == 0);
        reti = (m_depth > 0) && ($urandom % 12 == 0);
        ireq = ($urandom % 5 == 0) ? (N_INT'($urandom) & N_INT'($urandom)) : '0;
        if ($urandom % 6 == 0) pin_n[$urandom % 2] = ~pin_n[$urandom % 2];
        glob = ($urandom % 10 != 0);
        tick(1);
      end
    end
    penult = 0; last = 0; ack = 0; reti = 0; ireq = '0; glob = 1; en = '1;

    // R1 reset discards a pending flag
    pin_n = '1; edge_m = 2'b11; idle(2);
    pulse(6'b000001); idle(1);
    rst = 1; tick(2); rst = 0;
    chk(0, 0, 0, "R1 cleared by reset");
    run_last(4); chk(0, 0, 0, "R1 pending flag discarded");

    finish_up();
  end
endmodule